// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is the integer datapath of a small load/store processor. It is built from one identical single-bit slice per operand bit. The slices combine two operands with bitwise AND, bitwise OR, addition, subtraction or a signed less-than compare. The block has no clock. Every output follows its inputs combinationally.

A two-bit select picks the leg of each slice's result multiplexer. A separate negate control inverts the second operand in every slice and also supplies the carry into the lowest slice. Setting it turns the adder into a subtractor that adds the two's complement of B. Carries ripple from each slice into the next higher one.

The compare uses no dedicated comparator. The top slice derives the true sign of the adder's result from its sum bit and the signed overflow. That sign is routed back to the fourth multiplexer leg of bit 0, and every higher slice sees a constant zero on that leg. The carry-out and the overflow flag always describe the adder, whichever leg is selected.

Top module: `bitslice_alu`

## Requirements
- R1: With select 00, each result bit is the AND of A and the effective B. The effective B is ~B when negate is 1 and B otherwise.
- R2: With select 01, each result bit is the OR of A and the effective B.
- R3: With select 10 and negate 0, the result is (A + B) mod 2^WIDTH, and the carry output is the unsigned carry out of the top bit.
- R4: With select 10 and negate 1, the result is (A - B) mod 2^WIDTH, and the carry output is 1 exactly when A >= B as unsigned numbers.
- R5: For every select value, the overflow output is 1 exactly when the adder's operation overflows as two's complement. That operation is A + B with negate 0, or A - B with negate 1.
- R6: With select 11 and negate 1, result bit 0 is 1 exactly when signed A < signed B, and bits WIDTH-1..1 are 0. This holds also when the subtraction overflows, for example with the most negative and most positive operands.
- R7: With select 11 and negate 0, result bit 0 is 1 exactly when the exact signed value of A + B is negative, and the upper bits are 0.
- R8: With select 00 or 01, the carry output still reports the carry out of the adder's current operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 2 | Result leg select: 00 AND, 01 OR, 10 sum, 11 compare |
| negate_b_i | input | 1 | Inverts B in every slice and forms the carry into bit 0 |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Signed overflow of the adder |

## Verification
Every output, including the compare bit that travels up the carry chain and back to bit 0, is due in the same cycle the operands change, because no register lies on any path. The bench changes its inputs just after a rising edge. It reads all three outputs at the following falling edge, half a period later, once the longest ripple path and the feedback to bit 0 have settled. The sweep covers every operand pair at a narrow width for all eight select and negate combinations. That includes the most negative and most positive values and equal operands, with the expected values worked out in integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        ALU_AND  = 2'b00,
        ALU_OR   = 2'b01,
        ALU_SUM  = 2'b10,
        ALU_LESS = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic res;
        logic sum;
        logic cout;
    } slice_out_t;

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half_x;

    assign half_x = a_i ^ b_i;
    assign s_o    = half_x ^ c_i;
    assign c_o    = (a_i & b_i) | (half_x & c_i);
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    inv_i,
    input  logic    c_i,
    input  logic    less_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    sum_o,
    output logic    c_o
);
    logic       b_eff;
    logic       fa_sum;
    logic       fa_co;
    slice_out_t out_d;

    assign b_eff = b_i ^ inv_i;

    alu_full_adder u_fa (
        .a_i (a_i),
        .b_i (b_eff),
        .c_i (c_i),
        .s_o (fa_sum),
        .c_o (fa_co)
    );

    always_comb begin
        out_d      = '0;
        out_d.sum  = fa_sum;
        out_d.cout = fa_co;
        unique case (op_i)
            ALU_AND:  out_d.res = a_i & b_eff;
            ALU_OR:   out_d.res = a_i | b_eff;
            ALU_SUM:  out_d.res = fa_sum;
            ALU_LESS: out_d.res = less_i;
            default:  out_d.res = 1'b0;
        endcase
    end

    assign res_o = out_d.res;
    assign sum_o = out_d.sum;
    assign c_o   = out_d.cout;
endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags (
    input  logic c_in_i,
    input  logic c_out_i,
    input  logic sum_i,
    output logic ovf_o,
    output logic set_o
);
    assign ovf_o = c_in_i ^ c_out_i;
    assign set_o = sum_i ^ ovf_o;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             negate_b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    alu_op_e op_sel;
    logic    set_w;
    logic    ovf_w;

    assign op_sel = alu_op_e'(op_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic ci;
        logic co;
        logic res;
        logic sum;
        logic less;

        if (i == 0) begin : g_lsb
            assign ci   = negate_b_i;
            assign less = set_w;
        end else begin : g_upper
            assign ci   = g_bit[i-1].co;
            assign less = 1'b0;
        end

        alu_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .inv_i  (negate_b_i),
            .c_i    (ci),
            .less_i (less),
            .op_i   (op_sel),
            .res_o  (res),
            .sum_o  (sum),
            .c_o    (co)
        );

        assign result_o[i] = res;
    end

    alu_msb_flags u_flags (
        .c_in_i  (g_bit[MSB].ci),
        .c_out_i (g_bit[MSB].co),
        .sum_i   (g_bit[MSB].sum),
        .ovf_o   (ovf_w),
        .set_o   (set_w)
    );

    assign carry_o = g_bit[MSB].co;
    assign ovf_o   = ovf_w;
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       op_i,
    input logic             negate_b_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             ovf_o
);
    localparam int M = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   ext;
    logic             ovf_ref;
    logic             lt_ref;

    always_comb begin
        b_eff   = b_i ^ {WIDTH{negate_b_i}};
        ext     = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, negate_b_i};
        ovf_ref = (a_i[M] == b_eff[M]) && (ext[M] != a_i[M]);
        lt_ref  = $signed(a_i) < $signed(b_i);

        if (op_i == 2'b00)
            p_and_leg_r1: assert (result_o == (a_i & b_eff));
        if (op_i == 2'b01)
            p_or_leg_r2: assert (result_o == (a_i | b_eff));
        if (op_i == 2'b10 && !negate_b_i)
            p_add_r3: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
        if (op_i == 2'b10 && negate_b_i)
            p_sub_borrow_r4: assert (carry_o == (a_i >= b_i));
        p_no_overflow_r5: assert (ovf_o == ovf_ref);
        if (op_i == 2'b11)
            p_cmp_upper_zero_r6: assert (result_o[M:1] == '0);
        if (op_i == 2'b11 && negate_b_i)
            p_cmp_signed_r6: assert (result_o[0] == lt_ref);
        if (op_i[1] == 1'b0)
            p_logic_carry_r8: assert (carry_o == ext[WIDTH]);
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i        (a_i),
    .b_i        (b_i),
    .op_i       (op_i),
    .negate_b_i (negate_b_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o)
);

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
    localparam int TW   = 6;
    localparam int SPAN = 1 << TW;
    localparam int MASK = SPAN - 1;
    localparam int HALF = SPAN / 2;

    logic          clk = 1'b0;
    logic [TW-1:0] a, b, res;
    logic [1:0]    op;
    logic          neg, co, ov;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #5 clk = ~clk;

    bitslice_alu #(.WIDTH(TW)) dut (
        .a_i        (a),
        .b_i        (b),
        .op_i       (op),
        .negate_b_i (neg),
        .result_o   (res),
        .carry_o    (co),
        .ovf_o      (ov)
    );

    task automatic chk(input string req, input int act, input int exp,
                       input int va, input int vb, input int vo, input int vn);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s a=%0d b=%0d op=%0d neg=%0d actual=%0d expected=%0d",
                     req, va, vb, vo, vn, act, exp);
        end
    endtask

    initial begin
        a = '0; b = '0; op = 2'b00; neg = 1'b0;
        @(negedge clk);
        chk("R1", int'(res), 0, 0, 0, 0, 0);
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 2; n++) begin
                for (int x = 0; x < SPAN; x++) begin
                    for (int y = 0; y < SPAN; y++) begin
                        int beff, tot, sx, sy, st, eres, eco, eov;
                        string rtag, ctag;
                        @(posedge clk);
                        a = TW'(x); b = TW'(y); op = 2'(o); neg = 1'(n);
                        beff = (n == 1) ? (~y & MASK) : y;
                        tot  = x + beff + n;
                        sx   = (x >= HALF) ? x - SPAN : x;
                        sy   = (y >= HALF) ? y - SPAN : y;
                        st   = (n == 1) ? sx - sy : sx + sy;
                        eco  = tot >> TW;
                        eov  = (st < -HALF || st > HALF - 1) ? 1 : 0;
                        case (o)
                            0: begin eres = x & beff; rtag = "R1"; end
                            1: begin eres = x | beff; rtag = "R2"; end
                            2: begin eres = tot & MASK; rtag = (n == 1) ? "R4" : "R3"; end
                            default: begin eres = (st < 0) ? 1 : 0; rtag = (n == 1) ? "R6" : "R7"; end
                        endcase
                        ctag = (o < 2) ? "R8" : ((n == 1) ? "R4" : "R3");
                        @(negedge clk);
                        chk(rtag, int'(res), eres, x, y, o, n);
                        chk(ctag, int'(co), eco, x, y, o, n);
                        chk("R5", int'(ov), eov, x, y, o, n);
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule